// File: doc/BRIEF.md
# Paired-Width Dual-Bank Register File

This block holds the general registers of a two-bank datapath. There are two banks, A and B, and each bank has sixteen 32-bit registers. Any register whose index is even can be joined with the next register above it to form one 40-bit operand. The even register supplies bits 31:0 of that operand and the low byte of the odd register supplies bits 39:32. Each bank has two registered read ports. On every cycle, each read port returns one of three things: a single register sign-extended to 40 bits, a 40-bit pair, or a 5-bit immediate sign-extended to 40 bits.

There are two write ports. Each write port picks a bank on every cycle and does one of four operations:
- a 32-bit word write;
- a 40-bit pair write, which updates both registers of the pair in the same cycle;
- a constant load into the low half, which sign-extends a 16-bit value into the whole register;
- a constant load into the high half, which replaces bits 31:16 and leaves bits 15:0 as they were.

The block flags pair accesses that name an odd base index. It also flags a cycle in which both write ports target the same bank.

Top module: `pair_regfile`

## Requirements
- R1: A synchronous reset clears every register in both banks, every read data output, every read error flag, the write error flags and the collision flag to zero.
- R2: A word write (kind 0) stores wr_data[31:0] into the addressed register. A narrow read (wide=0, imm_sel=0) returns that register sign-extended to 40 bits on the clock edge that samples the address.
- R3: A wide read (wide=1, imm_sel=0) with an even address e returns {reg[e+1][7:0], reg[e][31:0]}.
- R4: A pair write (kind 1) with an even address e writes wr_data[31:0] to reg[e] and {24'b0, wr_data[39:32]} to reg[e+1] in the same cycle. The upper 24 bits of the odd register are therefore cleared.
- R5: A wide read with an odd address sets that port's error flag and returns zero. A pair write with an odd address sets wr_err for that port on the next edge and leaves both banks unchanged.
- R6: When imm_sel is 1, the port returns its 5-bit immediate sign-extended to 40 bits, whatever the address and wide inputs are.
- R7: A low-half constant load (kind 2) writes the 16-bit constant, sign-extended to 32 bits, to the whole register.
- R8: A high-half constant load (kind 3) replaces bits 31:16 with the constant and keeps bits 15:0.
- R9: A read of a register that is written in the same cycle returns the value held before that write. There is no bypass.
- R10: If both write ports are enabled and select the same bank (wr_bank 0 = A, 1 = B), port 0 is performed, port 1 is dropped, and wr_coll is 1 after that edge.
- R11: Writes from the two ports to different banks in one cycle both take effect, and neither bank changes the other. In that case wr_coll stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rda_addr | input | 2x4 | Bank A read port register indices |
| rda_wide | input | 2 | Bank A read ports: 1 selects a 40-bit pair |
| rda_imm_sel | input | 2 | Bank A read ports: 1 selects the immediate |
| rda_imm | input | 2x5 | Bank A read port immediates |
| rda_data | output | 2x40 | Bank A read port operands (registered) |
| rda_err | output | 2 | Bank A read port illegal-pair flags (registered) |
| rdb_addr | input | 2x4 | Bank B read port register indices |
| rdb_wide | input | 2 | Bank B read ports: 1 selects a 40-bit pair |
| rdb_imm_sel | input | 2 | Bank B read ports: 1 selects the immediate |
| rdb_imm | input | 2x5 | Bank B read port immediates |
| rdb_data | output | 2x40 | Bank B read port operands (registered) |
| rdb_err | output | 2 | Bank B read port illegal-pair flags (registered) |
| wr_en | input | 2 | Write port enables |
| wr_bank | input | 2 | Write port bank select, 0 = A, 1 = B |
| wr_kind | input | 2x2 | Write kind: 0 word, 1 pair, 2 low constant, 3 high constant |
| wr_addr | input | 2x4 | Write register indices |
| wr_data | input | 2x40 | Write data for the word and pair kinds |
| wr_k16 | input | 2x16 | Constant for the two constant-load kinds |
| wr_err | output | 2 | Illegal-pair write flags per port (registered) |
| wr_coll | output | 1 | Same-bank write collision flag (registered) |

## Verification
The hardest case to reach from the ports is one where the odd register of a pair still holds nonzero upper bits when the pair is overwritten. Those bits are not visible in a wide read, so a stale value would go unnoticed. To reach it, the stimulus first fills the odd register with all ones through a word write, then does a pair write over it, and finally reads the odd register narrow. The narrow read must show the cleared upper bits. The collision case with different indices is set up in a similar way: port 1 targets a register that port 0 does not touch, so dropping port 1 shows up as an unchanged register and cannot be hidden by port 0's write.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;
  typedef enum logic [1:0] {
    WK_WORD = 2'd0,
    WK_PAIR = 2'd1,
    WK_CLO  = 2'd2,
    WK_CHI  = 2'd3
  } wkind_e;
endpackage

// File: rtl/rf_wdec.sv
// Decodes one write request into per-halfword lane enables for the even and odd arrays.
module rf_wdec
  import dbrf_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int EXT_W = 8,
  parameter int AW    = 4,
  parameter int K_W   = 16
) (
  input  logic                   en,
  input  logic [1:0]             kind,
  input  logic [AW-1:0]          addr,
  input  logic [REG_W+EXT_W-1:0] data,
  input  logic [K_W-1:0]         k,
  output logic                   ev_lo,
  output logic                   ev_hi,
  output logic                   od_lo,
  output logic                   od_hi,
  output logic                   pair,
  output logic [AW-2:0]          idx,
  output logic [REG_W-1:0]       ev_val,
  output logic [REG_W-1:0]       od_val,
  output logic                   illegal
);
  localparam int OPW = REG_W + EXT_W;

  logic [REG_W-1:0] word_v;
  logic [REG_W-1:0] clo_v;
  logic [REG_W-1:0] chi_v;

  assign word_v = data[REG_W-1:0];
  assign clo_v  = {{(REG_W-K_W){k[K_W-1]}}, k};
  assign chi_v  = {k, {(REG_W-K_W){1'b0}}};
  assign idx    = addr[AW-1:1];

  always_comb begin
    ev_lo   = 1'b0;
    ev_hi   = 1'b0;
    od_lo   = 1'b0;
    od_hi   = 1'b0;
    pair    = 1'b0;
    ev_val  = word_v;
    od_val  = word_v;
    illegal = en && (kind == WK_PAIR) && addr[0];
    if (en) begin
      unique case (wkind_e'(kind))
        WK_WORD: begin
          od_lo = addr[0];
          od_hi = addr[0];
          ev_lo = !addr[0];
          ev_hi = !addr[0];
        end
        WK_PAIR: begin
          ev_val = data[REG_W-1:0];
          od_val = {{(REG_W-EXT_W){1'b0}}, data[OPW-1:REG_W]};
          if (!addr[0]) begin
            ev_lo = 1'b1;
            ev_hi = 1'b1;
            od_lo = 1'b1;
            od_hi = 1'b1;
            pair  = 1'b1;
          end
        end
        WK_CLO: begin
          ev_val = clo_v;
          od_val = clo_v;
          od_lo  = addr[0];
          od_hi  = addr[0];
          ev_lo  = !addr[0];
          ev_hi  = !addr[0];
        end
        default: begin
          ev_val = chi_v;
          od_val = chi_v;
          od_hi  = addr[0];
          ev_hi  = !addr[0];
        end
      endcase
    end
  end
endmodule

// File: rtl/rf_rdfmt.sv
// Forms one 40-bit operand from the addressed even/odd words or the immediate.
module rf_rdfmt #(
  parameter int REG_W = 32,
  parameter int EXT_W = 8,
  parameter int IMM_W = 5
) (
  input  logic [REG_W-1:0]       ev,
  input  logic [REG_W-1:0]       od,
  input  logic                   odd_sel,
  input  logic                   wide,
  input  logic                   imm_sel,
  input  logic [IMM_W-1:0]       imm,
  output logic [REG_W+EXT_W-1:0] val,
  output logic                   bad
);
  localparam int OPW = REG_W + EXT_W;

  logic [REG_W-1:0] word;
  assign word = odd_sel ? od : ev;

  always_comb begin
    bad = 1'b0;
    if (imm_sel) begin
      val = {{(OPW-IMM_W){imm[IMM_W-1]}}, imm};
    end else if (wide) begin
      bad = odd_sel;
      val = odd_sel ? '0 : {od[EXT_W-1:0], ev};
    end else begin
      val = {{EXT_W{word[REG_W-1]}}, word};
    end
  end
endmodule

// File: rtl/rf_bank.sv
// One bank: even and odd word arrays with halfword write lanes and registered read ports.
module rf_bank #(
  parameter int REG_W = 32,
  parameter int EXT_W = 8,
  parameter int NREG  = 16,
  parameter int NRD   = 2,
  parameter int IMM_W = 5,
  parameter int AW    = $clog2(NREG)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ev_lo,
  input  logic                              ev_hi,
  input  logic                              od_lo,
  input  logic                              od_hi,
  input  logic                              wr_pair,
  input  logic [AW-2:0]                     wr_idx,
  input  logic [REG_W-1:0]                  ev_val,
  input  logic [REG_W-1:0]                  od_val,
  input  logic [NRD-1:0][AW-1:0]            rd_addr,
  input  logic [NRD-1:0]                    rd_wide,
  input  logic [NRD-1:0]                    rd_imm_sel,
  input  logic [NRD-1:0][IMM_W-1:0]         rd_imm,
  output logic [NRD-1:0][REG_W+EXT_W-1:0]   rd_val_q,
  output logic [NRD-1:0]                    rd_bad_q
);
  localparam int OPW   = REG_W + EXT_W;
  localparam int NPAIR = NREG / 2;
  localparam int HW    = REG_W / 2;

  logic [REG_W-1:0] mem_ev [NPAIR];
  logic [REG_W-1:0] mem_od [NPAIR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAIR; i++) begin
        mem_ev[i] <= '0;
        mem_od[i] <= '0;
      end
    end else begin
      if (ev_lo) mem_ev[wr_idx][HW-1:0]     <= ev_val[HW-1:0];
      if (ev_hi) mem_ev[wr_idx][REG_W-1:HW] <= ev_val[REG_W-1:HW];
      if (od_lo) mem_od[wr_idx][HW-1:0]     <= od_val[HW-1:0];
      if (od_hi) mem_od[wr_idx][REG_W-1:HW] <= od_val[REG_W-1:HW];
    end
  end

  // R4
  pair_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pair |=> (mem_od[$past(wr_idx)][REG_W-1:EXT_W] == '0));

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [OPW-1:0] fmt_val;
    logic           fmt_bad;

    rf_rdfmt #(.REG_W(REG_W), .EXT_W(EXT_W), .IMM_W(IMM_W)) u_fmt (
      .ev      (mem_ev[rd_addr[r][AW-1:1]]),
      .od      (mem_od[rd_addr[r][AW-1:1]]),
      .odd_sel (rd_addr[r][0]),
      .wide    (rd_wide[r]),
      .imm_sel (rd_imm_sel[r]),
      .imm     (rd_imm[r]),
      .val     (fmt_val),
      .bad     (fmt_bad)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_val_q[r] <= '0;
        rd_bad_q[r] <= 1'b0;
      end else begin
        rd_val_q[r] <= fmt_val;
        rd_bad_q[r] <= fmt_bad;
      end
    end

    // R5
    rd_bad_cause_chk: assert property (@(posedge clk) disable iff (rst)
      rd_bad_q[r] |-> $past(rd_wide[r] && rd_addr[r][0] && !rd_imm_sel[r]));

    // R6
    imm_sext_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rd_imm_sel[r]) |->
        (rd_val_q[r][OPW-1:IMM_W-1] == '0) || (rd_val_q[r][OPW-1:IMM_W-1] == '1));

    // R2
    word_sext_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rd_wide[r] && !rd_imm_sel[r]) |->
        (rd_val_q[r][OPW-1:REG_W-1] == '0) || (rd_val_q[r][OPW-1:REG_W-1] == '1));
  end
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile #(
  parameter int REG_W = 32,
  parameter int EXT_W = 8,
  parameter int NREG  = 16,
  parameter int NRD   = 2,
  parameter int NWR   = 2,
  parameter int IMM_W = 5,
  parameter int K_W   = 16,
  parameter int AW    = $clog2(NREG),
  parameter int OPW   = REG_W + EXT_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NRD-1:0][AW-1:0]        rda_addr,
  input  logic [NRD-1:0]                rda_wide,
  input  logic [NRD-1:0]                rda_imm_sel,
  input  logic [NRD-1:0][IMM_W-1:0]     rda_imm,
  output logic [NRD-1:0][OPW-1:0]       rda_data,
  output logic [NRD-1:0]                rda_err,
  input  logic [NRD-1:0][AW-1:0]        rdb_addr,
  input  logic [NRD-1:0]                rdb_wide,
  input  logic [NRD-1:0]                rdb_imm_sel,
  input  logic [NRD-1:0][IMM_W-1:0]     rdb_imm,
  output logic [NRD-1:0][OPW-1:0]       rdb_data,
  output logic [NRD-1:0]                rdb_err,
  input  logic [NWR-1:0]                wr_en,
  input  logic [NWR-1:0]                wr_bank,
  input  logic [NWR-1:0][1:0]           wr_kind,
  input  logic [NWR-1:0][AW-1:0]        wr_addr,
  input  logic [NWR-1:0][OPW-1:0]       wr_data,
  input  logic [NWR-1:0][K_W-1:0]       wr_k16,
  output logic [NWR-1:0]                wr_err,
  output logic                          wr_coll
);
  localparam int NBANK = 2;

  logic [NWR-1:0]            d_ev_lo, d_ev_hi, d_od_lo, d_od_hi, d_pair, d_ill;
  logic [NWR-1:0][AW-2:0]    d_idx;
  logic [NWR-1:0][REG_W-1:0] d_ev_val, d_od_val;

  for (genvar p = 0; p < NWR; p++) begin : g_wdec
    rf_wdec #(.REG_W(REG_W), .EXT_W(EXT_W), .AW(AW), .K_W(K_W)) u_dec (
      .en      (wr_en[p]),
      .kind    (wr_kind[p]),
      .addr    (wr_addr[p]),
      .data    (wr_data[p]),
      .k       (wr_k16[p]),
      .ev_lo   (d_ev_lo[p]),
      .ev_hi   (d_ev_hi[p]),
      .od_lo   (d_od_lo[p]),
      .od_hi   (d_od_hi[p]),
      .pair    (d_pair[p]),
      .idx     (d_idx[p]),
      .ev_val  (d_ev_val[p]),
      .od_val  (d_od_val[p]),
      .illegal (d_ill[p])
    );
  end

  logic coll_now;
  assign coll_now = wr_en[0] && wr_en[1] && (wr_bank[0] == wr_bank[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_err  <= '0;
      wr_coll <= 1'b0;
    end else begin
      wr_err  <= d_ill;
      wr_coll <= coll_now;
    end
  end

  // R10
  coll_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_coll |-> $past(wr_en[0] && wr_en[1] && (wr_bank[0] == wr_bank[1])));

  logic [NBANK-1:0][NRD-1:0][AW-1:0]    b_addr;
  logic [NBANK-1:0][NRD-1:0]            b_wide, b_imm_sel, b_bad;
  logic [NBANK-1:0][NRD-1:0][IMM_W-1:0] b_imm;
  logic [NBANK-1:0][NRD-1:0][OPW-1:0]   b_val;

  assign b_addr[0]    = rda_addr;
  assign b_addr[1]    = rdb_addr;
  assign b_wide[0]    = rda_wide;
  assign b_wide[1]    = rdb_wide;
  assign b_imm_sel[0] = rda_imm_sel;
  assign b_imm_sel[1] = rdb_imm_sel;
  assign b_imm[0]     = rda_imm;
  assign b_imm[1]     = rdb_imm;
  assign rda_data     = b_val[0];
  assign rdb_data     = b_val[1];
  assign rda_err      = b_bad[0];
  assign rdb_err      = b_bad[1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             s0, s1;
    logic             m_ev_lo, m_ev_hi, m_od_lo, m_od_hi, m_pair;
    logic [AW-2:0]    m_idx;
    logic [REG_W-1:0] m_ev_val, m_od_val;

    // port 0 has priority when both ports address this bank
    assign s0 = wr_en[0] && (wr_bank[0] == 1'(b));
    assign s1 = wr_en[1] && (wr_bank[1] == 1'(b)) && !s0;

    always_comb begin
      m_ev_lo  = 1'b0;
      m_ev_hi  = 1'b0;
      m_od_lo  = 1'b0;
      m_od_hi  = 1'b0;
      m_pair   = 1'b0;
      m_idx    = d_idx[0];
      m_ev_val = d_ev_val[0];
      m_od_val = d_od_val[0];
      if (s0) begin
        m_ev_lo = d_ev_lo[0];
        m_ev_hi = d_ev_hi[0];
        m_od_lo = d_od_lo[0];
        m_od_hi = d_od_hi[0];
        m_pair  = d_pair[0];
      end else if (s1) begin
        m_ev_lo  = d_ev_lo[1];
        m_ev_hi  = d_ev_hi[1];
        m_od_lo  = d_od_lo[1];
        m_od_hi  = d_od_hi[1];
        m_pair   = d_pair[1];
        m_idx    = d_idx[1];
        m_ev_val = d_ev_val[1];
        m_od_val = d_od_val[1];
      end
    end

    rf_bank #(.REG_W(REG_W), .EXT_W(EXT_W), .NREG(NREG), .NRD(NRD),
              .IMM_W(IMM_W), .AW(AW)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .ev_lo      (m_ev_lo),
      .ev_hi      (m_ev_hi),
      .od_lo      (m_od_lo),
      .od_hi      (m_od_hi),
      .wr_pair    (m_pair),
      .wr_idx     (m_idx),
      .ev_val     (m_ev_val),
      .od_val     (m_od_val),
      .rd_addr    (b_addr[b]),
      .rd_wide    (b_wide[b]),
      .rd_imm_sel (b_imm_sel[b]),
      .rd_imm     (b_imm[b]),
      .rd_val_q   (b_val[b]),
      .rd_bad_q   (b_bad[b])
    );
  end
endmodule

// File: tb/pair_regfile_tb_top.sv
`timescale 1ns/1ps
module pair_regfile_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0][3:0]  rda_addr, rdb_addr;
  logic [1:0]       rda_wide, rdb_wide, rda_imm_sel, rdb_imm_sel;
  logic [1:0][4:0]  rda_imm, rdb_imm;
  logic [1:0][39:0] rda_data, rdb_data;
  logic [1:0]       rda_err, rdb_err;
  logic [1:0]       wr_en, wr_bank, wr_err;
  logic [1:0][1:0]  wr_kind;
  logic [1:0][3:0]  wr_addr;
  logic [1:0][39:0] wr_data;
  logic [1:0][15:0] wr_k16;
  logic             wr_coll;

  pair_regfile dut_i (
    .clk(clk), .rst(rst),
    .rda_addr(rda_addr), .rda_wide(rda_wide), .rda_imm_sel(rda_imm_sel),
    .rda_imm(rda_imm), .rda_data(rda_data), .rda_err(rda_err),
    .rdb_addr(rdb_addr), .rdb_wide(rdb_wide), .rdb_imm_sel(rdb_imm_sel),
    .rdb_imm(rdb_imm), .rdb_data(rdb_data), .rdb_err(rdb_err),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_kind(wr_kind), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_k16(wr_k16), .wr_err(wr_err), .wr_coll(wr_coll)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // {bank, kind, addr, wdata, k16, wide, expected}
  localparam int NV = 7;
  localparam logic [103:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'd3, 40'h00_8000_0001, 16'h0000, 1'b0, 40'hFF_8000_0001},
    {1'b0, 2'd0, 4'd2, 40'h00_1234_5678, 16'h0000, 1'b0, 40'h00_1234_5678},
    {1'b0, 2'd1, 4'd4, 40'hAB_CAFE_F00D, 16'h0000, 1'b1, 40'hAB_CAFE_F00D},
    {1'b1, 2'd2, 4'd7, 40'h00_0000_0000, 16'h8001, 1'b0, 40'hFF_FFFF_8001},
    {1'b1, 2'd3, 4'd7, 40'h00_0000_0000, 16'h1234, 1'b0, 40'h00_1234_8001},
    {1'b1, 2'd0, 4'd9, 40'h00_7FFF_FFFF, 16'h0000, 1'b0, 40'h00_7FFF_FFFF},
    {1'b1, 2'd1, 4'd8, 40'h01_0000_0000, 16'h0000, 1'b1, 40'h01_0000_0000}
  };
  localparam string VREQ [NV] = '{"R2", "R2", "R3/R4", "R7", "R8", "R2", "R3/R4"};

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rda_addr = '0; rdb_addr = '0; rda_wide = '0; rdb_wide = '0;
    rda_imm_sel = '0; rdb_imm_sel = '0; rda_imm = '0; rdb_imm = '0;
    wr_en = '0; wr_bank = '0; wr_kind = '0; wr_addr = '0; wr_data = '0; wr_k16 = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int p, input logic bank, input logic [1:0] kind,
                    input logic [3:0] addr, input logic [39:0] data, input logic [15:0] k);
    wr_en[p] = 1'b1; wr_bank[p] = bank; wr_kind[p] = kind;
    wr_addr[p] = addr; wr_data[p] = data; wr_k16[p] = k;
  endtask

  task automatic rd(input int p, input logic bank, input logic [3:0] addr, input logic wide);
    if (bank == 1'b0) begin
      rda_addr[p] = addr; rda_wide[p] = wide;
    end else begin
      rdb_addr[p] = addr; rdb_wide[p] = wide;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(0, 1'b0, 4'd0, 1'b1); rd(1, 1'b1, 4'd14, 1'b1);
    tick();
    chk("R1 rda_data0", rda_data[0], 40'h0);
    chk("R1 rdb_data1", rdb_data[1], 40'h0);
    chk("R1 flags", {38'h0, rda_err[0], wr_coll}, 40'h0);

    // table walk: write port 0, then read back on read port 0 of that bank
    for (int i = 0; i < NV; i++) begin
      logic [103:0] v;
      v = VEC[i];
      idle();
      wr(0, v[103], v[102:101], v[100:97], v[96:57], v[56:41]);
      tick();
      idle();
      rd(0, v[103], v[100:97], v[40]);
      tick();
      chk(VREQ[i], v[103] ? rdb_data[0] : rda_data[0], v[39:0]);
    end

    // R4: stale upper bits of the odd register are cleared by a pair write
    idle(); wr(0, 1'b0, 2'd0, 4'd5, 40'h00_FFFF_FFFF, 16'h0); tick();
    idle(); wr(0, 1'b0, 2'd1, 4'd4, 40'h3C_0000_0011, 16'h0); tick();
    idle(); rd(0, 1'b0, 4'd5, 1'b0); rd(1, 1'b0, 4'd4, 1'b1); tick();
    chk("R4 odd narrow", rda_data[0], 40'h00_0000_003C);
    chk("R3 pair wide", rda_data[1], 40'h3C_0000_0011);

    // R5: odd-base wide read
    idle(); rd(0, 1'b0, 4'd5, 1'b0); rd(1, 1'b0, 4'd5, 1'b1); tick();
    chk("R5 rd err", {38'h0, rda_err}, 40'h2);
    chk("R5 rd data", rda_data[1], 40'h0);

    // R5: odd-base pair write is suppressed
    idle(); wr(0, 1'b1, 2'd0, 4'd3, 40'h00_0000_0055, 16'h0); tick();
    idle(); wr(0, 1'b1, 2'd1, 4'd3, 40'hFF_FFFF_FFFF, 16'h0); tick();
    chk("R5 wr_err", {38'h0, wr_err}, 40'h1);
    idle(); rd(0, 1'b1, 4'd3, 1'b0); rd(1, 1'b1, 4'd2, 1'b0); tick();
    chk("R5 B3 kept", rdb_data[0], 40'h00_0000_0055);
    chk("R5 B2 kept", rdb_data[1], 40'h0);

    // R6: immediates ignore the addressed register
    idle();
    rdb_addr[0] = 4'd9; rdb_imm_sel[0] = 1'b1; rdb_imm[0] = 5'b11011;
    rdb_addr[1] = 4'd8; rdb_wide[1] = 1'b1; rdb_imm_sel[1] = 1'b1; rdb_imm[1] = 5'b01111;
    tick();
    chk("R6 neg imm", rdb_data[0], 40'hFF_FFFF_FFFB);
    chk("R6 pos imm", rdb_data[1], 40'h00_0000_000F);

    // R9: read during write returns the old value
    idle(); wr(0, 1'b0, 2'd0, 4'd6, 40'h111, 16'h0); tick();
    idle(); wr(0, 1'b0, 2'd0, 4'd6, 40'h222, 16'h0); rd(0, 1'b0, 4'd6, 1'b0); tick();
    chk("R9 old value", rda_data[0], 40'h111);
    idle(); rd(0, 1'b0, 4'd6, 1'b0); tick();
    chk("R9 new value", rda_data[0], 40'h222);

    // R10: collisions, same index and different index
    idle(); wr(0, 1'b0, 2'd0, 4'd10, 40'h1010, 16'h0); wr(1, 1'b0, 2'd0, 4'd10, 40'h2020, 16'h0); tick();
    chk("R10 coll flag", {39'h0, wr_coll}, 40'h1);
    idle(); wr(0, 1'b0, 2'd0, 4'd12, 40'h12, 16'h0); wr(1, 1'b0, 2'd0, 4'd13, 40'h13, 16'h0);
    rd(0, 1'b0, 4'd10, 1'b0); tick();
    chk("R10 port0 wins", rda_data[0], 40'h1010);
    idle(); rd(0, 1'b0, 4'd13, 1'b0); rd(1, 1'b0, 4'd12, 1'b0); tick();
    chk("R10 port1 dropped", rda_data[0], 40'h0);
    chk("R10 port0 done", rda_data[1], 40'h12);

    // R11: simultaneous writes to different banks
    idle(); wr(0, 1'b1, 2'd0, 4'd0, 40'h77, 16'h0); wr(1, 1'b0, 2'd0, 4'd0, 40'h66, 16'h0); tick();
    chk("R11 no coll", {39'h0, wr_coll}, 40'h0);
    idle(); rd(0, 1'b0, 4'd0, 1'b0); rd(1, 1'b1, 4'd0, 1'b0); tick();
    chk("R11 bank A", rda_data[0], 40'h66);
    chk("R11 bank B", rdb_data[1], 40'h77);

    // R1: reset clears stored contents
    idle(); wr(0, 1'b0, 2'd0, 4'd1, 40'h5, 16'h0); tick();
    idle(); rst = 1'b1; tick(); tick(); rst = 1'b0;
    rd(0, 1'b0, 4'd1, 1'b0); tick();
    chk("R1 cleared", rda_data[0], 40'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule